// File: doc/BRIEF.md
# Data-Driven Burst Clock Generator

This block makes a local clock that runs only while there is work to do. It runs from a fast reference clock. A producer offers a data word, a cycle count and a half period over a valid/ready handshake. Once the word is taken, the block drives a clean square wave on its clock output. The wave always starts with a low phase, so the captured word is settled before the first rising edge. After the requested number of full cycles the output rests low. The block raises a one-cycle completion flag and waits for the next word.

The consumer can use the square wave directly as a clock. It can also use the one-cycle rise strobe as a clock enable inside the reference domain. The captured word is presented on the data output and held for the whole burst. No synchronizer is needed on the data path.

Top module: `burst_clock_gen`

## Requirements
- R1: While reset is asserted and after it is released, `clkOut`, `clkRise`, `busy` and `burstDone` are 0 and `reqReady` is 1.
- R2: A word is taken on a reference edge where `reqValid` and `reqReady` are both 1. If `reqCycles` is nonzero, the burst starts on that edge. `clkOut` is then low for H reference cycles, high for H, and repeats.
- R3: A burst with count k gives exactly k high phases on `clkOut`. The burst lasts 2*H*k reference cycles. On the edge that ends the last high phase, `clkOut` returns low, `busy` falls and `burstDone` is 1 for one cycle.
- R4: H is the value of `halfTicks` taken with the word. A value of 0 is treated as 1. Later changes to `halfTicks` do not affect a running burst.
- R5: `reqReady` is 0 and `busy` is 1 during a burst. A request offered then is not taken. It changes neither `dataOut` nor the burst.
- R6: A word with `reqCycles` = 0 is taken at once. `burstDone` is 1 in the following cycle, and `clkOut` stays low.
- R7: `clkOut` is low whenever the block is idle. Every phase of `clkOut` lasts exactly H reference cycles, so no runt pulse occurs at start or stop.
- R8: `dataOut` takes `reqData` on the accepting edge of a nonzero-count word. It holds that value until the next such word.
- R9: `clkRise` is 1 for exactly the first reference cycle of each high phase of `clkOut`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Producer offers a word |
| reqReady | output | 1 | Block can take a word |
| reqData | input | DATA_W | Word to hand to the consumer |
| reqCycles | input | CNT_W | Output clock cycles for this word |
| halfTicks | input | HALF_W | Half period in reference cycles |
| clkOut | output | 1 | Gated burst clock |
| clkRise | output | 1 | One-cycle strobe at each rising edge of clkOut |
| dataOut | output | DATA_W | Captured word |
| busy | output | 1 | Burst in progress |
| burstDone | output | 1 | One-cycle completion flag |

## Verification
The bench uses the default widths of 8, 4 and 4 bits. With these widths the largest count (15) and the largest half period (15) can both be reached, and a burst stays within 450 reference cycles. That makes the extremes practical: the longest burst, a half period of zero, a count of zero and single-tick phases. Random words are mixed in, and many of them offer a competing request during the burst.

// File: rtl/burst_clock_pkg.sv
package burst_clock_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } burstState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture word, half period, restart phase
    logic run;    // burst active, phase counter advances
  } burstStrobes_t;

endpackage

// File: rtl/burst_clock_ctrl.sv
module burst_clock_ctrl
  import burst_clock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCycles,
  input  logic             halfEnd,
  input  logic             clkLevel,
  output logic             reqReady,
  output logic             busy,
  output logic             burstDone,
  output burstStrobes_t    strobes
);

  burstState_t      state;
  logic [CNT_W-1:0] cyclesLeft;
  logic             doneReg;
  logic             accept;
  logic             zeroCount;
  logic             highEnds;

  assign reqReady  = (state == ST_IDLE);
  assign accept    = reqReady && reqValid;
  assign zeroCount = (reqCycles == '0);
  assign highEnds  = halfEnd && clkLevel;

  assign strobes.load = accept && !zeroCount;
  assign strobes.run  = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cyclesLeft <= '0;
      doneReg    <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (zeroCount) begin
              doneReg <= 1'b1;
            end else begin
              state      <= ST_RUN;
              cyclesLeft <= reqCycles;
            end
          end
        end
        ST_RUN: begin
          if (highEnds) begin
            if (cyclesLeft == CNT_W'(1)) begin
              state   <= ST_IDLE;
              doneReg <= 1'b1;
            end
            cyclesLeft <= cyclesLeft - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state == ST_RUN);
  assign burstDone = doneReg;

  // R7: idle control never sees a high clock level from the datapath
  p_idle_clock_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !clkLevel);

  // R3: a burst never runs with zero cycles remaining
  p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (cyclesLeft != '0));

endmodule

// File: rtl/burst_clock_datapath.sv
module burst_clock_datapath
  import burst_clock_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobes_t     strobes,
  input  logic [DATA_W-1:0] reqData,
  input  logic [HALF_W-1:0] halfTicks,
  output logic              halfEnd,
  output logic              clkLevel,
  output logic              clkRise,
  output logic [DATA_W-1:0] dataOut
);

  localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(1);

  logic [HALF_W-1:0] hpReg;
  logic [HALF_W-1:0] hpLast;
  logic [HALF_W-1:0] hpEff;
  logic [HALF_W-1:0] phaseCnt;
  logic              level;
  logic              riseReg;
  logic [DATA_W-1:0] dataReg;

  assign hpEff   = (halfTicks == '0) ? MIN_HALF : halfTicks;
  assign hpLast  = hpReg - 1'b1;
  assign halfEnd = strobes.run && (phaseCnt == hpLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hpReg    <= MIN_HALF;
      phaseCnt <= '0;
      level    <= 1'b0;
      riseReg  <= 1'b0;
      dataReg  <= '0;
    end else if (strobes.load) begin
      hpReg    <= hpEff;
      phaseCnt <= '0;
      level    <= 1'b0;
      riseReg  <= 1'b0;
      dataReg  <= reqData;
    end else if (strobes.run) begin
      if (halfEnd) begin
        phaseCnt <= '0;
        level    <= !level;
        riseReg  <= !level;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
        riseReg  <= 1'b0;
      end
    end else begin
      phaseCnt <= '0;
      level    <= 1'b0;
      riseReg  <= 1'b0;
    end
  end

  assign clkLevel = level;
  assign clkRise  = riseReg;
  assign dataOut  = dataReg;

  // R7: every toggle inside a burst happens only after a full phase
  p_full_phase_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.run) && (level != $past(level))) |-> ($past(phaseCnt) == $past(hpLast)));

  // R8: the captured word is held through a running burst
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.run) && strobes.run) |-> $stable(dataReg));

  // R4: the half period does not change while a burst runs
  p_half_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.run) && strobes.run) |-> $stable(hpReg));

  // R4: a stored half period is never zero
  p_half_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    hpReg != '0);

endmodule

// File: rtl/burst_clock_gen.sv
module burst_clock_gen
  import burst_clock_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [DATA_W-1:0] reqData,
  input  logic [CNT_W-1:0]  reqCycles,
  input  logic [HALF_W-1:0] halfTicks,
  output logic              clkOut,
  output logic              clkRise,
  output logic [DATA_W-1:0] dataOut,
  output logic              busy,
  output logic              burstDone
);

  burstStrobes_t strobes;
  logic          halfEnd;
  logic          clkLevel;

  burst_clock_ctrl #(.CNT_W(CNT_W)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCycles (reqCycles),
    .halfEnd   (halfEnd),
    .clkLevel  (clkLevel),
    .reqReady  (reqReady),
    .busy      (busy),
    .burstDone (burstDone),
    .strobes   (strobes)
  );

  burst_clock_datapath #(.DATA_W(DATA_W), .HALF_W(HALF_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqData   (reqData),
    .halfTicks (halfTicks),
    .halfEnd   (halfEnd),
    .clkLevel  (clkLevel),
    .clkRise   (clkRise),
    .dataOut   (dataOut)
  );

  assign clkOut = clkLevel;

  // R3: completion is flagged only with the output clock at rest
  p_done_clock_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (!clkOut && !busy));

  // R9: the rise strobe accompanies each rising edge of the clock
  p_rise_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |-> clkRise);

  // R9: the strobe never appears with the clock low
  p_rise_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    clkRise |-> clkOut);

  // R5: no word is offered as taken while a burst runs
  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

endmodule

// File: tb/burst_clock_gen_test.sv
module burst_clock_gen_test;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;
  localparam int HALF_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [DATA_W-1:0] reqData = '0;
  logic [CNT_W-1:0]  reqCycles = '0;
  logic [HALF_W-1:0] halfTicks = '0;
  logic              clkOut;
  logic              clkRise;
  logic [DATA_W-1:0] dataOut;
  logic              busy;
  logic              burstDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_clock_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HALF_W(HALF_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqData(reqData), .reqCycles(reqCycles), .halfTicks(halfTicks),
    .clkOut(clkOut), .clkRise(clkRise), .dataOut(dataOut),
    .busy(busy), .burstDone(burstDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int effHalf(input int hp);
    return (hp == 0) ? 1 : hp;
  endfunction

  // t = reference edges since the accepting edge
  function automatic int expClk(input int t, input int hp, input int total);
    if (t >= total) return 0;
    return (t / hp) % 2;
  endfunction

  function automatic int expRise(input int t, input int hp, input int total);
    if (t >= total) return 0;
    return ((t % (2 * hp)) == hp) ? 1 : 0;
  endfunction

  task automatic runWord(input int data, input int k, input int hp, input bit stall,
                         input int hpChange);
    int hpE;
    int total;
    int lastData;
    hpE = effHalf(hp);
    total = 2 * hpE * k;
    lastData = dataOut;
    @(negedge clk);
    check("R5 ready before offer", reqReady, 1);
    reqValid  = 1'b1;
    reqData   = DATA_W'(data);
    reqCycles = CNT_W'(k);
    halfTicks = HALF_W'(hp);
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t <= total; t++) begin
      check("R2 R7 clkOut", clkOut, expClk(t, hpE, total));
      check("R9 clkRise", clkRise, expRise(t, hpE, total));
      if (k == 0) begin
        check("R6 done on zero count", burstDone, 1);
        check("R6 busy on zero count", busy, 0);
        check("R8 data kept on zero count", dataOut, lastData);
      end else begin
        check("R3 done timing", burstDone, (t == total) ? 1 : 0);
        check("R5 busy", busy, (t < total) ? 1 : 0);
        check("R5 ready", reqReady, (t < total) ? 0 : 1);
        check("R8 R5 data held", dataOut, data);
      end
      if (stall && (t + 1 < total)) begin
        reqValid  = 1'b1;
        reqData   = DATA_W'(~data);
        reqCycles = CNT_W'(1);
        halfTicks = HALF_W'(hpChange);
      end else begin
        reqValid = 1'b0;
      end
      if (t < total) @(negedge clk);
    end
    reqValid = 1'b0;
    @(negedge clk);
    check("R3 single done pulse", burstDone, 0);
    check("R7 idle low", clkOut, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 clkOut in reset", clkOut, 0);
    check("R1 ready in reset", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 clkOut", clkOut, 0);
    check("R1 clkRise", clkRise, 0);
    check("R1 busy", busy, 0);
    check("R1 done", burstDone, 0);
    check("R1 ready", reqReady, 1);

    runWord(8'hA5, 1, 1, 1'b0, 0);   // R2 single tick phases
    runWord(8'h3C, 0, 5, 1'b0, 0);   // R6 zero count
    runWord(8'h5A, 3, 0, 1'b1, 7);   // R4 zero half period
    runWord(8'h0F, 15, 15, 1'b1, 1); // R3 longest burst, R4 change ignored
    runWord(8'h11, 2, 3, 1'b1, 9);   // R5 competing request
    runWord(8'h22, 0, 0, 1'b0, 0);   // R6 back-to-back zero count
    for (int i = 0; i < 40; i++) begin
      runWord(int'($urandom_range(255)), int'($urandom_range(15)),
              int'($urandom_range(15)), bit'($urandom_range(1)),
              int'($urandom_range(15)));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule